// File: doc/BRIEF.md
# Bus Clock Output Controller

This block divides the oscillator clock by two to make the internal bus clock and decides whether that clock is driven onto the external clock pin. At reset the pin drive depends on the operating mode: off in normal single-chip mode and on in special single-chip mode. Software can override the reset default with a write strobe. In peripheral mode the pin is an input, so the block never drives it.

The clock runs from a phase state machine with four states: `PH_LOW`, `PH_HIGH`, `PH_STRETCH` and `PH_STOP`. The transitions are as follows:
- `PH_LOW` moves to `PH_HIGH`, or to `PH_STOP` when a stop is requested.
- `PH_HIGH` moves to `PH_LOW`, or to `PH_STRETCH` when extra cycles are pending.
- `PH_STRETCH` stays in `PH_STRETCH` until its count runs out, then moves to `PH_LOW`.
- `PH_STOP` stays in `PH_STOP` while the stop request is held and moves to `PH_LOW` when it is released.

A slow-access strobe sampled in the low phase lengthens the next high phase by 0 to 3 oscillator cycles.

A second machine controls the pin. It has three states: `PS_OFF`, `PS_DRIVE` and `PS_INPUT`. It moves to `PS_INPUT` at once whenever the mode is a peripheral mode. Otherwise it chooses between `PS_OFF` and `PS_DRIVE` only while the bus clock sits in `PH_LOW` or `PH_STOP`. This rule means a change of enable can never cut a clock pulse short.

Top module: `bus_clk_ctl`

## Requirements
- R1: With no stop request and no stretch, `bus_clk` alternates one oscillator cycle high and one cycle low. The first high cycle follows the first rising edge after reset is released.
- R2: Mode encoding: 2'b00 is normal single-chip, 2'b01 is special single-chip, and 2'b10 and 2'b11 are peripheral. In normal single-chip mode with no software write, `pin_oe` and `pin_out` stay 0.
- R3: In special single-chip mode with no software write, `pin_oe` is 1 from the first edge after reset, and `pin_out` equals `bus_clk`.
- R4: A cycle with `en_wr`=1 stores `en_wdata` (1 means drive, 0 means release). The stored value replaces the mode default from the next low phase onward.
- R5: `pin_out` rises only in the same cycle as `bus_clk` rises. In the single-chip modes it falls only in the same cycle as `bus_clk` falls, so no shortened pulse appears on the pin.
- R6: In a peripheral mode, `pin_oe` and `pin_out` stay 0 whatever is written, while `bus_clk` keeps running.
- R7: If `slow_acc` is 1 during a low-phase cycle and `stretch_cnt` is N, the following high phase lasts 1+N cycles. `stretching` is 1 during exactly the N extra cycles.
- R8: When `slow_acc` is 0 during the low phase, `stretch_cnt` is ignored and the high phase lasts one cycle.
- R9: A `stop_req` seen in a low-phase cycle holds `bus_clk` and `pin_out` at 0 for as long as it stays asserted. A request raised in a high phase lets that high cycle finish before the clock halts low.
- R10: After `stop_req` drops, `bus_clk` stays low for exactly one more cycle and then goes high.
- R11: While `rst_n` is 0, `bus_clk`, `pin_out`, `pin_oe` and `stretching` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode (see R2) |
| stop_req | input | 1 | Stop mode request; halts the clock low |
| en_wr | input | 1 | Write strobe for the pin enable |
| en_wdata | input | 1 | Pin enable value written with `en_wr` |
| stretch_cnt | input | STRETCH_W | Extra high-phase cycles for a slow access |
| slow_acc | input | 1 | Slow-access strobe, sampled in the low phase |
| bus_clk | output | 1 | Internal bus clock |
| pin_out | output | 1 | Value driven to the external clock pin |
| pin_oe | output | 1 | Output enable of the external clock pin |
| stretching | output | 1 | High during the inserted stretch cycles |

## Verification
The bench builds the block with the default `STRETCH_W` of 2. This width makes every stretch count from 0 up to the largest value, 3, reachable in directed tests. It also covers the edge case of a nonzero count paired with an idle strobe. The three mode defaults are each tested, and so are software overrides in both directions. Stop requests are raised in both the low and the high phase, so both the halt path and the restart path are covered.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [1:0] {
        PH_LOW     = 2'd0,
        PH_HIGH    = 2'd1,
        PH_STRETCH = 2'd2,
        PH_STOP    = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_DRIVE = 2'd1,
        PS_INPUT = 2'd2
    } pin_state_t;

    localparam logic [1:0] MD_NORMAL  = 2'b00;
    localparam logic [1:0] MD_SPECIAL = 2'b01;

    function automatic logic is_periph(input logic [1:0] md);
        return md[1];
    endfunction

endpackage

// File: rtl/bcg_phase_fsm.sv
module bcg_phase_fsm
    import bcg_pkg::*;
#(
    parameter int STRETCH_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stop_req,
    input  logic                 slow_acc,
    input  logic [STRETCH_W-1:0] stretch_cnt,
    output logic                 phase_low,
    output logic                 clk_nxt,
    output logic                 bus_clk,
    output logic                 stretching
);

    localparam logic [STRETCH_W-1:0] REM_ZERO = '0;
    localparam logic [STRETCH_W-1:0] REM_ONE  = STRETCH_W'(1);

    phase_t               ph_q, ph_nxt;
    logic [STRETCH_W-1:0] rem_q, rem_nxt;

    always_comb begin
        ph_nxt  = ph_q;
        rem_nxt = rem_q;
        unique case (ph_q)
            PH_LOW: begin
                if (stop_req) begin
                    ph_nxt  = PH_STOP;
                    rem_nxt = REM_ZERO;
                end else begin
                    ph_nxt  = PH_HIGH;
                    rem_nxt = slow_acc ? stretch_cnt : REM_ZERO;
                end
            end
            PH_HIGH: begin
                ph_nxt = (rem_q != REM_ZERO) ? PH_STRETCH : PH_LOW;
            end
            PH_STRETCH: begin
                rem_nxt = rem_q - REM_ONE;
                ph_nxt  = (rem_q == REM_ONE) ? PH_LOW : PH_STRETCH;
            end
            PH_STOP: begin
                ph_nxt = stop_req ? PH_STOP : PH_LOW;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= PH_LOW;
            rem_q <= REM_ZERO;
        end else begin
            ph_q  <= ph_nxt;
            rem_q <= rem_nxt;
        end
    end

    assign clk_nxt   = (ph_nxt == PH_HIGH) || (ph_nxt == PH_STRETCH);
    assign phase_low = (ph_q == PH_LOW) || (ph_q == PH_STOP);

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_clk    <= 1'b0;
            stretching <= 1'b0;
        end else begin
            bus_clk    <= clk_nxt;
            stretching <= (ph_nxt == PH_STRETCH);
        end
    end

    // R7
    stretch_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretching |-> bus_clk);

    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !bus_clk) |=> !bus_clk);

    // R1
    low_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_clk && !stop_req && ph_q == PH_LOW) |=> bus_clk);

    // R10
    restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_STOP && !stop_req) |=> (!bus_clk && ph_q == PH_LOW));

endmodule

// File: rtl/bcg_pin_ctl.sv
module bcg_pin_ctl
    import bcg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       en_wr,
    input  logic       en_wdata,
    input  logic       phase_low,
    input  logic       clk_nxt,
    output logic       pin_out,
    output logic       pin_oe
);

    pin_state_t ps_q, ps_nxt;
    logic       sw_set_q;
    logic       sw_val_q;
    logic       want_drive;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_set_q <= 1'b0;
            sw_val_q <= 1'b0;
        end else if (en_wr) begin
            sw_set_q <= 1'b1;
            sw_val_q <= en_wdata;
        end
    end

    assign want_drive = sw_set_q ? sw_val_q : (mode == MD_SPECIAL);

    always_comb begin
        ps_nxt = ps_q;
        if (is_periph(mode)) begin
            ps_nxt = PS_INPUT;
        end else if (phase_low) begin
            unique case (ps_q)
                PS_OFF:   ps_nxt = want_drive ? PS_DRIVE : PS_OFF;
                PS_DRIVE: ps_nxt = want_drive ? PS_DRIVE : PS_OFF;
                PS_INPUT: ps_nxt = want_drive ? PS_DRIVE : PS_OFF;
                default:  ps_nxt = PS_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= PS_OFF;
        else        ps_q <= ps_nxt;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_oe  <= 1'b0;
            pin_out <= 1'b0;
        end else begin
            pin_oe  <= (ps_nxt == PS_DRIVE);
            pin_out <= (ps_nxt == PS_DRIVE) && clk_nxt;
        end
    end

    // R6
    periph_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_periph(mode) |=> (!pin_oe && !pin_out));

endmodule

// File: rtl/bus_clk_ctl.sv
module bus_clk_ctl
    import bcg_pkg::*;
#(
    parameter int STRETCH_W = 2
) (
    input  logic                 osc_clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic                 stop_req,
    input  logic                 en_wr,
    input  logic                 en_wdata,
    input  logic [STRETCH_W-1:0] stretch_cnt,
    input  logic                 slow_acc,
    output logic                 bus_clk,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 stretching
);

    logic phase_low;
    logic clk_nxt;

    bcg_phase_fsm #(.STRETCH_W(STRETCH_W)) u_phase (
        .clk         (osc_clk),
        .rst_n       (rst_n),
        .stop_req    (stop_req),
        .slow_acc    (slow_acc),
        .stretch_cnt (stretch_cnt),
        .phase_low   (phase_low),
        .clk_nxt     (clk_nxt),
        .bus_clk     (bus_clk),
        .stretching  (stretching)
    );

    bcg_pin_ctl u_pin (
        .clk       (osc_clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .phase_low (phase_low),
        .clk_nxt   (clk_nxt),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // R5
    pin_rise_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(pin_out) |-> $rose(bus_clk));

    // R5
    pin_fall_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        ($fell(pin_out) && !is_periph(mode)) |-> $fell(bus_clk));

    // R3
    pin_follow_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        pin_oe |-> (pin_out == bus_clk));

endmodule

// File: tb/test_bus_clk_ctl.sv
module test_bus_clk_ctl;

    logic       osc_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       stop_req = 1'b0;
    logic       en_wr = 1'b0;
    logic       en_wdata = 1'b0;
    logic [1:0] stretch_cnt = 2'd0;
    logic       slow_acc = 1'b0;
    logic       bus_clk, pin_out, pin_oe, stretching;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 osc_clk = ~osc_clk;

    bus_clk_ctl #(.STRETCH_W(2)) i_bus_clk_ctl (
        .osc_clk(osc_clk), .rst_n(rst_n), .mode(mode), .stop_req(stop_req),
        .en_wr(en_wr), .en_wdata(en_wdata), .stretch_cnt(stretch_cnt),
        .slow_acc(slow_acc), .bus_clk(bus_clk), .pin_out(pin_out),
        .pin_oe(pin_oe), .stretching(stretching)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge osc_clk);
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst_n = 1'b0; mode = m; stop_req = 0; en_wr = 0; slow_acc = 0; stretch_cnt = 0;
        repeat (3) step();
        chk(!bus_clk && !pin_out && !pin_oe && !stretching, "R11 reset outputs",
            {bus_clk, pin_out, pin_oe, stretching}, 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_low();
        while (bus_clk) step();
    endtask

    task automatic t_toggle_normal();
        do_reset(2'b00);
        for (int i = 0; i < 8; i++) begin
            step();
            chk(bus_clk == ((i % 2) == 0), "R1 toggle", bus_clk, (i % 2) == 0);
            chk(!pin_oe && !pin_out, "R2 normal default off", {pin_oe, pin_out}, 0);
        end
    endtask

    task automatic t_special_default();
        do_reset(2'b01);
        for (int i = 0; i < 6; i++) begin
            step();
            chk(pin_oe, "R3 special oe", pin_oe, 1);
            chk(pin_out == bus_clk, "R3 special follows", pin_out, bus_clk);
        end
    endtask

    task automatic t_sw_enable();
        do_reset(2'b00);
        step();
        while (!bus_clk) step();
        en_wr = 1; en_wdata = 1;
        step();
        en_wr = 0;
        chk(!pin_out && !bus_clk, "R5 no early pin pulse", pin_out, 0);
        for (int i = 0; i < 6; i++) begin
            step();
            chk(pin_out == bus_clk, "R4 enabled follows", pin_out, bus_clk);
        end
        chk(pin_oe, "R4 enabled oe", pin_oe, 1);
    endtask

    task automatic t_sw_disable();
        do_reset(2'b01);
        repeat (3) step();
        en_wr = 1; en_wdata = 0;
        step();
        en_wr = 0;
        repeat (3) step();
        for (int i = 0; i < 4; i++) begin
            chk(!pin_oe && !pin_out, "R4 disabled", {pin_oe, pin_out}, 0);
            step();
        end
    endtask

    task automatic t_periph();
        int rises = 0;
        logic prev;
        do_reset(2'b10);
        step();
        en_wr = 1; en_wdata = 1;
        step();
        en_wr = 0;
        prev = bus_clk;
        for (int i = 0; i < 8; i++) begin
            step();
            if (bus_clk && !prev) rises++;
            prev = bus_clk;
            chk(!pin_oe && !pin_out, "R6 periph no drive", {pin_oe, pin_out}, 0);
        end
        chk(rises >= 3, "R6 clock runs", rises, 4);
    endtask

    task automatic t_stretch(input int n, input bit strobe, input string tag);
        int hi = 0;
        int st = 0;
        wait_low();
        slow_acc = strobe; stretch_cnt = 2'(n);
        step();
        slow_acc = 0; stretch_cnt = 0;
        while (bus_clk && hi < 10) begin
            hi++;
            if (stretching) st++;
            step();
        end
        chk(hi == (strobe ? n + 1 : 1), {tag, " high length"}, hi, strobe ? n + 1 : 1);
        chk(st == (strobe ? n : 0), {tag, " stretch flag"}, st, strobe ? n : 0);
    endtask

    task automatic t_stop(input bit in_high);
        if (in_high) begin
            while (!bus_clk) step();
        end else begin
            wait_low();
        end
        stop_req = 1;
        for (int i = 0; i < 8; i++) begin
            step();
            chk(!bus_clk && !pin_out, "R9 held low", bus_clk, 0);
        end
        stop_req = 0;
        step();
        chk(!bus_clk, "R10 one low cycle", bus_clk, 0);
        step();
        chk(bus_clk, "R10 restart high", bus_clk, 1);
    endtask

    initial begin
        t_toggle_normal();
        t_special_default();
        t_sw_enable();
        t_sw_disable();
        t_periph();
        do_reset(2'b01);
        repeat (2) step();
        t_stretch(0, 1, "R7 n0");
        t_stretch(1, 1, "R7 n1");
        t_stretch(2, 1, "R7 n2");
        t_stretch(3, 1, "R7 n3");
        t_stretch(3, 0, "R8 no strobe");
        t_stop(0);
        t_stop(1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule